// File: doc/BRIEF.md
# Shared-Timebase Edge-Placed PWM Generator

This block drives sixteen pulse-width-modulated lines from one common timebase. A prescaler divides the input clock by `prescale + 1`, and each prescaler wrap moves an 8-bit step counter forward. The step counter runs from 0 up to `period`, so every line repeats after `(prescale + 1) * (period + 1)` clocks. Prescale and period are global. Each channel only has a rise position, a fall position and an enable bit.

A channel has no duty-cycle setting. It goes high on the first clock of the step that equals its rise value, and goes low on the first clock of the step that equals its fall value. If both values are equal, the line inverts once per period, which gives a square wave at twice the period. An edge value of `period + 1` is never reached, so that edge never fires and the line holds a constant level. A fall value below the rise value gives an inverted waveform.

A one-cycle strobe marks the start of each period. All configuration arrives as already-registered inputs from an enclosing register block.

Top module: `pwm_edge_gen`

## Requirements
- R1: While `rst_i` is high, every `pwm_o` bit and `period_start_o` are 0 at the following clock edge, and both counters restart at zero.
- R2: With constant configuration, every output repeats with a period of exactly `(prescale_i + 1) * (period_i + 1)` clocks. The step counter moves on only when the prescaler wraps, and it wraps to 0 after reaching `period_i`.
- R3: `period_start_o` is high for one clock, starting one clock after the cycle in which both counters are zero. When `prescale_i` and `period_i` are both 0 it is high on every clock.
- R4: An enabled channel goes to 1 one clock after the step counter enters the step equal to its rise value, and to 0 one clock after it enters the step equal to its fall value. The high span is therefore `(fall - rise) * (prescale_i + 1)` clocks.
- R5: When a channel's rise and fall values are equal, its output inverts exactly once each time that step is entered, and at no other time.
- R6: A fall value lower than the rise value yields a line that is low from the fall step up to the rise step and high for the rest of the period.
- R7: An edge value of `period_i + 1` never fires, so a channel can hold a constant 1 or a constant 0. With `period_i` = 255, every 8-bit value is reached, and no constant level is possible.
- R8: A channel whose enable bit is 0 outputs 0. After its enable bit is set, the line starts at 0 and changes only at its next edge match.
- R9: Bit i of `en_lo_i` enables channel i, and bit i of `en_hi_i` enables channel 8 + i.
- R10: Channel c takes its rise value from `rise_i[c*8 +: 8]` and its fall value from `fall_i[c*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| prescale_i | input | 8 | Clock divider minus one, shared by all channels |
| period_i | input | 8 | Last step index of the period, shared by all channels |
| rise_i | input | 128 | Packed per-channel rise step values |
| fall_i | input | 128 | Packed per-channel fall step values |
| en_lo_i | input | 8 | Enables for channels 0 to 7 |
| en_hi_i | input | 8 | Enables for channels 8 to 15 |
| pwm_o | output | 16 | Registered PWM lines, bit c is channel c |
| period_start_o | output | 1 | One-clock strobe at each period start |

## Verification
The timebase assertions assume that `prescale_i` and `period_i` stay constant between resets. Changing them mid-run could leave a counter above its new limit for one pass. Edge values and enables may change on any clock. The stimulus therefore writes new prescale and period values only while reset is held, and it toggles enable bits in the middle of running periods. A cycle-indexed reference in the bench derives the prescaler phase and the step from the clock count since reset, and predicts every line and the strobe from that.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_SET  = 2'd1,
    EDGE_CLR  = 2'd2,
    EDGE_FLIP = 2'd3
  } edge_act_e;

  // Decide what a channel does on the first clock of a step.
  function automatic edge_act_e pick_action(input logic first_clk,
                                            input logic hit_rise,
                                            input logic hit_fall);
    edge_act_e act;
    act = EDGE_NONE;
    if (first_clk) begin
      if (hit_rise && hit_fall) act = EDGE_FLIP;
      else if (hit_rise)        act = EDGE_SET;
      else if (hit_fall)        act = EDGE_CLR;
    end
    return act;
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             at_zero_o,
  output logic             wrap_o
);

  logic [PRE_W-1:0] cnt_q;

  // The >= compare keeps a counter above a lowered limit from running away.
  assign wrap_o    = (cnt_q >= limit_i);
  assign at_zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + PRE_W'(1);
    end
  end

endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter #(
  parameter int STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              advance_i,
  input  logic              pre_zero_i,
  input  logic [STEP_W-1:0] limit_i,
  output logic [STEP_W-1:0] step_o,
  output logic              start_o
);

  logic [STEP_W-1:0] step_q;
  logic              start_q;
  logic              at_last;

  assign at_last = (step_q >= limit_i);
  assign step_o  = step_q;
  assign start_o = start_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      step_q <= '0;
    end else if (advance_i) begin
      step_q <= at_last ? '0 : step_q + STEP_W'(1);
    end
  end

  // Registered so the strobe lines up with channel outputs for edge value 0.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      start_q <= 1'b0;
    end else begin
      start_q <= pre_zero_i && (step_q == '0);
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              en_i,
  input  logic              first_clk_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [STEP_W-1:0] rise_i,
  input  logic [STEP_W-1:0] fall_i,
  output logic              pwm_o
);

  logic      out_q;
  edge_act_e act;

  always_comb begin
    act = pick_action(first_clk_i, step_i == rise_i, step_i == fall_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      out_q <= 1'b0;
    end else begin
      unique case (act)
        EDGE_SET:  out_q <= 1'b1;
        EDGE_CLR:  out_q <= 1'b0;
        EDGE_FLIP: out_q <= ~out_q;
        default:   out_q <= out_q;
      endcase
    end
  end

  assign pwm_o = out_q;

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen #(
  parameter int PRE_W    = 8,
  parameter int STEP_W   = 8,
  parameter int EN_GRP_W = 8,
  localparam int NUM_CH  = 2 * EN_GRP_W,
  localparam int EDGE_W  = NUM_CH * STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [PRE_W-1:0]  prescale_i,
  input  logic [STEP_W-1:0] period_i,
  input  logic [EDGE_W-1:0] rise_i,
  input  logic [EDGE_W-1:0] fall_i,
  input  logic [EN_GRP_W-1:0] en_lo_i,
  input  logic [EN_GRP_W-1:0] en_hi_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic              period_start_o
);

  logic [NUM_CH-1:0] en_all;
  logic              pre_zero;
  logic              pre_wrap;
  logic [STEP_W-1:0] step_q;

  assign en_all = {en_hi_i, en_lo_i};

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .limit_i   (prescale_i),
    .at_zero_o (pre_zero),
    .wrap_o    (pre_wrap)
  );

  pwm_step_counter #(.STEP_W(STEP_W)) u_step (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .advance_i  (pre_wrap),
    .pre_zero_i (pre_zero),
    .limit_i    (period_i),
    .step_o     (step_q),
    .start_o    (period_start_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.STEP_W(STEP_W)) u_ch (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .en_i        (en_all[c]),
      .first_clk_i (pre_zero),
      .step_i      (step_q),
      .rise_i      (rise_i[c*STEP_W +: STEP_W]),
      .fall_i      (fall_i[c*STEP_W +: STEP_W]),
      .pwm_o       (pwm_o[c])
    );
  end

endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk #(
  parameter int PRE_W  = 8,
  parameter int STEP_W = 8,
  parameter int NUM_CH = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic [PRE_W-1:0]         prescale,
  input logic [STEP_W-1:0]        period,
  input logic [NUM_CH*STEP_W-1:0] rise,
  input logic [NUM_CH*STEP_W-1:0] fall,
  input logic [NUM_CH-1:0]        en,
  input logic [NUM_CH-1:0]        pwm,
  input logic                     start,
  input logic                     pre_zero,
  input logic                     pre_wrap,
  input logic [STEP_W-1:0]        step
);

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    step <= period); // R2

  AST_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !pre_wrap |=> $stable(step)); // R2

  AST_START_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    start |-> $past(pre_zero && step == '0)); // R3

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (start && (prescale != '0 || period != '0)) |=> !start); // R3

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $rose(pwm[c]) |-> $past(en[c] && pre_zero && step == rise[c*STEP_W +: STEP_W])); // R4

    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm[c]) |-> $past(!en[c] || (pre_zero && step == fall[c*STEP_W +: STEP_W]))); // R4

    AST_MIDSTEP_STABLE: assert property (@(posedge clk) disable iff (rst)
      $past(en[c] && !pre_zero) |-> $stable(pwm[c])); // R5

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
      $past(!en[c]) |-> !pwm[c]); // R8
  end

endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(
  .PRE_W  (PRE_W),
  .STEP_W (STEP_W),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk      (clk_i),
  .rst      (rst_i),
  .prescale (prescale_i),
  .period   (period_i),
  .rise     (rise_i),
  .fall     (fall_i),
  .en       (en_all),
  .pwm      (pwm_o),
  .start    (period_start_o),
  .pre_zero (pre_zero),
  .pre_wrap (pre_wrap),
  .step     (step_q)
);

// File: tb/test_pwm_edge_gen.sv
`timescale 1ns/1ps
module test_pwm_edge_gen;

  localparam int NCH = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [7:0]      pre_v = '0;
  logic [7:0]      per_v = '0;
  logic [NCH*8-1:0] rise_bus = '0;
  logic [NCH*8-1:0] fall_bus = '0;
  logic [NCH-1:0]  en_v = '0;
  logic [NCH-1:0]  pwm;
  logic            strobe;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int n      = 0;
  logic [NCH-1:0] lvl = '0;
  bit done = 1'b0;

  typedef struct {
    int            due;
    logic [NCH-1:0] pwm;
    logic          strb;
    string         tag;
  } item_t;

  item_t sb[$];

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  pwm_edge_gen i_pwm_edge_gen (
    .clk_i          (clk),
    .rst_i          (rst),
    .prescale_i     (pre_v),
    .period_i       (per_v),
    .rise_i         (rise_bus),
    .fall_i         (fall_bus),
    .en_lo_i        (en_v[7:0]),
    .en_hi_i        (en_v[15:8]),
    .pwm_o          (pwm),
    .period_start_o (strobe)
  );

  // Monitor: compare results due at this negedge.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (pwm !== it.pwm) begin
        errors++;
        $display("FAIL %s pwm actual=%h expected=%h cycle=%0d", it.tag, pwm, it.pwm, cyc);
      end
      checks++;
      if (strobe !== it.strb) begin
        errors++;
        $display("FAIL R3 strobe actual=%b expected=%b cycle=%0d", strobe, it.strb, cyc);
      end
    end
  end

  task automatic push(logic [NCH-1:0] p, logic s, string tag);
    item_t it;
    it.due = cyc + 1;
    it.pwm = p;
    it.strb = s;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // R1: reset edge must clear everything.
  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    push('0, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    lvl = '0;
  endtask

  // Driver: predict the edge about to happen from the clock count since reset.
  task automatic step(string tag);
    int pi, s, r, f;
    pi = n % (int'(pre_v) + 1);
    s  = (n / (int'(pre_v) + 1)) % (int'(per_v) + 1);
    for (int c = 0; c < NCH; c++) begin
      r = int'(rise_bus[c*8 +: 8]);
      f = int'(fall_bus[c*8 +: 8]);
      if (!en_v[c]) lvl[c] = 1'b0;
      else if (pi == 0) begin
        if (s == r && s == f) lvl[c] = ~lvl[c];
        else if (s == r)      lvl[c] = 1'b1;
        else if (s == f)      lvl[c] = 1'b0;
      end
    end
    push(lvl, (pi == 0 && s == 0), tag);
    n++;
    @(negedge clk);
  endtask

  task automatic run(int cycles, string tag);
    for (int k = 0; k < cycles; k++) step(tag);
  endtask

  task automatic set_ch(int c, int r, int f, bit e);
    rise_bus[c*8 +: 8] = 8'(r);
    fall_bus[c*8 +: 8] = 8'(f);
    en_v[c] = e;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    // Mixed channel set: R2 R4 R5 R6 R7 R9 R10
    pre_v = 8'd2; per_v = 8'd9;
    for (int c = 0; c < NCH; c++) set_ch(c, 10, 10, 1'b1);
    set_ch(0, 2, 6, 1'b1);
    set_ch(1, 7, 3, 1'b1);
    set_ch(2, 4, 4, 1'b1);
    set_ch(3, 0, 10, 1'b1);
    set_ch(4, 10, 0, 1'b1);
    set_ch(5, 1, 5, 1'b0);
    set_ch(8, 3, 8, 1'b1);
    set_ch(9, 1, 2, 1'b0);
    set_ch(15, 9, 0, 1'b1);
    do_reset();
    run(70, "R2 R4 R5 R6 R7 R9 R10");

    // Enable a channel mid-period: R8
    en_v[5] = 1'b1;
    run(20, "R8");
    en_v[9] = 1'b1;
    en_v[0] = 1'b0;
    run(45, "R8 R9");

    // Shortest period, strobe every clock: R2 R3 R5
    pre_v = 8'd0; per_v = 8'd0;
    for (int c = 0; c < NCH; c++) set_ch(c, 1, 1, 1'b1);
    set_ch(0, 0, 0, 1'b1);
    set_ch(1, 0, 1, 1'b1);
    set_ch(12, 1, 0, 1'b1);
    do_reset();
    run(20, "R2 R3 R5");

    // Full 256-step period, every value reachable: R7
    pre_v = 8'd0; per_v = 8'd255;
    for (int c = 0; c < NCH; c++) set_ch(c, 0, 0, 1'b0);
    set_ch(0, 0, 255, 1'b1);
    set_ch(1, 5, 5, 1'b1);
    set_ch(14, 255, 0, 1'b1);
    do_reset();
    run(600, "R7");

    // Longer prescale, inverted and normal lanes: R2 R4 R6 R10
    pre_v = 8'd5; per_v = 8'd3;
    for (int c = 0; c < NCH; c++) set_ch(c, 4, 4, 1'b1);
    set_ch(0, 1, 3, 1'b1);
    set_ch(7, 3, 1, 1'b1);
    set_ch(11, 0, 2, 1'b1);
    do_reset();
    run(60, "R2 R4 R6 R10");

    do_reset();
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule